// File: doc/BRIEF.md
# Camera Frame Sync Timing Generator

This block sits behind a serial camera receiver and turns its decoded packet events into parallel video timing on the pixel clock. The receiver reports four kinds of single-cycle event: frame start, line start, line end and frame end. From these the block produces a vertical sync, a horizontal sync and a pixel-valid strobe. Horizontal sync and pixel valid are high only while a line's payload is being delivered.

Three programmable gaps shape the timing, and each has its own counter. The lead-in runs from vertical sync rising to the first horizontal sync. The line gap runs from one horizontal sync falling to the next one rising. The tail runs from the last horizontal sync falling to vertical sync falling. A line start that arrives too early is held in a one-entry slot until its gap runs out.

A 32-bit configuration word carries the gaps, a pixel format code and a data lane count. A new configuration is stored at once but takes effect only at the next accepted frame start. A separate 5-bit enable word switches the clock lane and the four data lanes. The block reports the set of data lanes that are in use.

Top module: `cam_sync_gen`

## Requirements
- R1: After reset, vsync, hsync, pix_valid, lane_act and pend_ovf are 0. fmt_err is 1, because the stored configuration and enable words are zero and format code 0 is reserved.
- R2: A frame_start pulse starts a frame only when the block is idle, bit 0 of the enable word (clock lane) is set and the stored format is legal. vsync is then 1 right after the edge that samples the pulse. In every other case the pulse is ignored.
- R3: The configuration word has these fields: line gap in [31:26], lead-in in [25:20], tail in [19:8], format in [7:2] and lane count in [1:0]. A write is stored at once. The gaps and lane count take effect only at the next accepted frame start, so a frame in progress keeps its own timing.
- R4: If a line start is pending or arrives, the first hsync rise of a frame comes exactly 1+L edges after the vsync rise edge, where L is the lead-in. A lead-in of 0 allows a rise on the next edge.
- R5: After an hsync fall at edge m, the next line rises at edge m+1+G, where G is the line gap, provided a line start is pending or arrives by then.
- R6: After a frame_end pulse has been seen, vsync falls once hsync is low and the tail count has run out. This is edge m+1+T after the last hsync fall at edge m, or edge k+1+T after the start edge k of a frame that has no lines, unless the frame end arrives later.
- R7: A line start that arrives during a line or while a gap is still counting is held in a one-entry pending slot and served when the gap expires. If one arrives while the slot is already full, pend_ovf is set and stays set until reset.
- R8: The legal 6-bit format codes are 0x1E, 0x2A, 0x2B, 0x2C and 0x30 to 0x33. fmt_err is 1 while the stored code is any other value. While fmt_err is 1, frame starts are refused.
- R9: For each i from 0 to 3, lane_act[i] = enable bit 0 AND enable bit i+1 AND (i <= lane count in force). Lane count 00 means one lane, 01 two lanes, 10 three lanes and 11 four lanes.
- R10: Clearing enable bit 0 drops vsync, hsync and pix_valid to 0 right after the write edge and abandons the frame.
- R11: hsync and pix_valid are equal. They are 1 from the edge that serves a line start to the edge that samples line_end. A line_end outside a line is ignored.
- R12: After a frame_end pulse, later line starts in that frame are ignored, and any pending line start is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_data | input | 32 | Configuration word |
| en_wr | input | 1 | Write strobe for the enable word |
| en_data | input | 5 | Enable word: bit 0 is the clock lane, bits 4:1 are data lanes 3..0 |
| frame_start | input | 1 | Frame start event pulse |
| line_start | input | 1 | Line start event pulse |
| line_end | input | 1 | Line end event pulse |
| frame_end | input | 1 | Frame end event pulse |
| vsync | output | 1 | Vertical sync |
| hsync | output | 1 | Horizontal sync |
| pix_valid | output | 1 | Pixel data valid |
| lane_act | output | 4 | Data lanes in use |
| fmt_err | output | 1 | Stored format code is reserved |
| pend_ovf | output | 1 | Sticky pending line-start overflow |

## Verification
Frame acceptance, the hsync fall on line end and the disabling of the clock lane all show up right after the very edge that samples the pulse or the write. Gap-timed edges come exactly 1+count edges after the edge they are measured from. The bench counts edges and reads the outputs one time unit after each edge. It records the edge index at which each output changes and compares the difference against 1+L, 1+G or 1+T. It draws the gaps, line widths, formats and lane settings at random, and adds directed cases for zero gaps, early line starts, reserved codes and configuration writes in the middle of a frame.

// File: rtl/cam_sync_pkg.sv
package cam_sync_pkg;
    localparam int GAP_W   = 6;
    localparam int LEAD_W  = 6;
    localparam int TAIL_W  = 12;
    localparam int FMT_W   = 6;
    localparam int CNT_W   = 2;
    localparam int N_LANES = 4;
    localparam int EN_W    = N_LANES + 1;
    localparam int CFG_W   = GAP_W + LEAD_W + TAIL_W + FMT_W + CNT_W;

    typedef struct packed {
        logic [GAP_W-1:0]  line_gap;
        logic [LEAD_W-1:0] lead_in;
        logic [TAIL_W-1:0] tail;
        logic [FMT_W-1:0]  fmt;
        logic [CNT_W-1:0]  lanes;
    } cfg_word_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_LINE = 2'd2
    } phase_t;

    function automatic logic fmt_legal(input logic [FMT_W-1:0] code);
        case (code)
            6'h1E, 6'h2A, 6'h2B, 6'h2C,
            6'h30, 6'h31, 6'h32, 6'h33: fmt_legal = 1'b1;
            default:                    fmt_legal = 1'b0;
        endcase
    endfunction

    function automatic logic [N_LANES-1:0] lane_mask(input logic [CNT_W-1:0] n);
        for (int i = 0; i < N_LANES; i++)
            lane_mask[i] = (i <= int'(n));
    endfunction
endpackage

// File: rtl/cam_gap_counter.sv
module cam_gap_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign is_zero = (cnt == '0);
endmodule

// File: rtl/cam_cfg_regs.sv
module cam_cfg_regs
    import cam_sync_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [CFG_W-1:0]    cfg_data,
    input  logic                en_wr,
    input  logic [EN_W-1:0]     en_data,
    input  logic                frame_take,
    output cfg_word_t           shadow,
    output cfg_word_t           active,
    output logic [EN_W-1:0]     en_q,
    output logic [N_LANES-1:0]  lane_act
);
    logic [N_LANES-1:0] mask_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
            en_q   <= '0;
        end else begin
            if (cfg_wr)     shadow <= cfg_word_t'(cfg_data);
            if (en_wr)      en_q   <= en_data;
            if (frame_take) active <= shadow;
        end
    end

    assign mask_w = lane_mask(active.lanes);

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        assign lane_act[i] = en_q[0] & en_q[i+1] & mask_w[i];
    end
endmodule

// File: rtl/cam_sync_fsm.sv
module cam_sync_fsm
    import cam_sync_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clk_lane_on,
    input  logic   fmt_ok,
    input  logic   fs,
    input  logic   ls,
    input  logic   le,
    input  logic   fe,
    input  logic   lead_z,
    input  logic   line_z,
    input  logic   tail_z,
    output phase_t phase,
    output logic   frame_take,
    output logic   line_fall,
    output logic   ovf
);
    phase_t phase_n;
    logic   pend, pend_n, endp, endp_n, ovf_n;
    logic   accept, ready;

    assign accept = ls && !endp && !fe;
    assign ready  = lead_z && line_z && !endp;

    always_comb begin
        phase_n    = phase;
        pend_n     = pend;
        endp_n     = endp;
        ovf_n      = ovf;
        frame_take = 1'b0;
        line_fall  = 1'b0;
        if (!clk_lane_on) begin
            phase_n = PH_IDLE;
            pend_n  = 1'b0;
            endp_n  = 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (fs && fmt_ok) begin
                        phase_n    = PH_WAIT;
                        frame_take = 1'b1;
                        pend_n     = 1'b0;
                        endp_n     = 1'b0;
                    end
                end
                PH_WAIT: begin
                    if (endp && tail_z) begin
                        phase_n = PH_IDLE;
                        pend_n  = 1'b0;
                        endp_n  = 1'b0;
                    end else if (fe) begin
                        endp_n = 1'b1;
                        pend_n = 1'b0;
                    end else if (ready && (pend || accept)) begin
                        phase_n = PH_LINE;
                        pend_n  = pend && accept;
                    end else if (accept) begin
                        if (pend) ovf_n  = 1'b1;
                        else      pend_n = 1'b1;
                    end
                end
                PH_LINE: begin
                    if (fe) begin
                        endp_n = 1'b1;
                        pend_n = 1'b0;
                    end else if (accept) begin
                        if (pend) ovf_n  = 1'b1;
                        else      pend_n = 1'b1;
                    end
                    if (le) begin
                        phase_n   = PH_WAIT;
                        line_fall = 1'b1;
                    end
                end
                default: phase_n = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            pend  <= 1'b0;
            endp  <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            phase <= phase_n;
            pend  <= pend_n;
            endp  <= endp_n;
            ovf   <= ovf_n;
        end
    end
endmodule

// File: rtl/cam_sync_gen.sv
module cam_sync_gen
    import cam_sync_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [CFG_W-1:0]    cfg_data,
    input  logic                en_wr,
    input  logic [EN_W-1:0]     en_data,
    input  logic                frame_start,
    input  logic                line_start,
    input  logic                line_end,
    input  logic                frame_end,
    output logic                vsync,
    output logic                hsync,
    output logic                pix_valid,
    output logic [N_LANES-1:0]  lane_act,
    output logic                fmt_err,
    output logic                pend_ovf
);
    cfg_word_t         shadow, active;
    logic [EN_W-1:0]   en_q;
    phase_t            phase;
    logic              frame_take, line_fall;
    logic              lead_z, line_z, tail_z;
    logic              fmt_ok, in_frame, in_wait;
    logic [TAIL_W-1:0] tail_val;

    assign fmt_ok   = fmt_legal(shadow.fmt);
    assign fmt_err  = !fmt_ok;
    assign in_frame = (phase != PH_IDLE);
    assign in_wait  = (phase == PH_WAIT);
    assign tail_val = frame_take ? shadow.tail : active.tail;

    cam_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_data   (cfg_data),
        .en_wr      (en_wr),
        .en_data    (en_data),
        .frame_take (frame_take),
        .shadow     (shadow),
        .active     (active),
        .en_q       (en_q),
        .lane_act   (lane_act)
    );

    cam_sync_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .clk_lane_on (en_q[0]),
        .fmt_ok      (fmt_ok),
        .fs          (frame_start),
        .ls          (line_start),
        .le          (line_end),
        .fe          (frame_end),
        .lead_z      (lead_z),
        .line_z      (line_z),
        .tail_z      (tail_z),
        .phase       (phase),
        .frame_take  (frame_take),
        .line_fall   (line_fall),
        .ovf         (pend_ovf)
    );

    cam_gap_counter #(.W(LEAD_W)) u_lead (
        .clk      (clk),
        .rst      (rst),
        .load     (frame_take),
        .load_val (shadow.lead_in),
        .dec      (in_frame),
        .is_zero  (lead_z)
    );

    cam_gap_counter #(.W(GAP_W)) u_line (
        .clk      (clk),
        .rst      (rst),
        .load     (frame_take || line_fall),
        .load_val (frame_take ? '0 : active.line_gap),
        .dec      (in_wait),
        .is_zero  (line_z)
    );

    cam_gap_counter #(.W(TAIL_W)) u_tail (
        .clk      (clk),
        .rst      (rst),
        .load     (frame_take || line_fall),
        .load_val (tail_val),
        .dec      (in_wait),
        .is_zero  (tail_z)
    );

    assign vsync     = in_frame && en_q[0];
    assign hsync     = (phase == PH_LINE) && en_q[0];
    assign pix_valid = hsync;
endmodule

// File: rtl/cam_sync_chk.sv
module cam_sync_chk
    import cam_sync_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               vsync,
    input logic               hsync,
    input logic               fmt_err,
    input logic               pend_ovf,
    input logic [N_LANES-1:0] lane_act,
    input logic [EN_W-1:0]    en_word
);
    // R11
    hs_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        hsync |-> vsync);

    // R4
    hs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> $past(vsync));

    // R10
    lane_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en_word[0] |-> (!vsync && !hsync && lane_act == '0));

    // R8
    bad_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (!vsync && fmt_err) |=> !vsync);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pend_ovf) |-> pend_ovf);

    // R9
    lane_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (lane_act & ~en_word[EN_W-1:1]) == '0);

    // R6
    vs_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(vsync) && en_word[0]) |-> (!hsync && !$past(hsync)));
endmodule

bind cam_sync_gen cam_sync_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .vsync    (vsync),
    .hsync    (hsync),
    .fmt_err  (fmt_err),
    .pend_ovf (pend_ovf),
    .lane_act (lane_act),
    .en_word  (en_q)
);

// File: tb/tb_cam_sync_gen.sv
`timescale 1ns/1ps
module tb_cam_sync_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0, en_wr = 1'b0;
    logic [31:0] cfg_data = '0;
    logic [4:0]  en_data = '0;
    logic        fs = 1'b0, ls = 1'b0, le = 1'b0, fe = 1'b0;
    logic        vsync, hsync, pix_valid, fmt_err, pend_ovf;
    logic [3:0]  lane_act;
    int          cyc = 0;
    int          nchk = 0, nerr = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cam_sync_gen dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .en_wr(en_wr), .en_data(en_data), .frame_start(fs),
        .line_start(ls), .line_end(le), .frame_end(fe),
        .vsync(vsync), .hsync(hsync), .pix_valid(pix_valid),
        .lane_act(lane_act), .fmt_err(fmt_err), .pend_ovf(pend_ovf)
    );

    function automatic logic [3:0] exp_mask(input logic [1:0] n);
        for (int i = 0; i < 4; i++) exp_mask[i] = (i <= int'(n));
    endfunction

    function automatic logic [5:0] legal_fmt(input int idx);
        case (idx)
            0: legal_fmt = 6'h1E; 1: legal_fmt = 6'h2A;
            2: legal_fmt = 6'h2B; 3: legal_fmt = 6'h2C;
            4: legal_fmt = 6'h30; 5: legal_fmt = 6'h31;
            6: legal_fmt = 6'h32; default: legal_fmt = 6'h33;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        fs = 0; ls = 0; le = 0; fe = 0; cfg_wr = 0; en_wr = 0;
    endtask

    task automatic write_cfg(input int g, input int l, input int t,
                             input logic [5:0] f, input logic [1:0] n);
        cfg_data = {g[5:0], l[5:0], t[11:0], f, n};
        cfg_wr = 1; tick();
    endtask

    task automatic write_en(input logic [4:0] e);
        en_data = e; en_wr = 1; tick();
    endtask

    task automatic wait_hs(output int c);
        int n = 0;
        while (!hsync && n < 5000) begin tick(); n++; end
        c = cyc;
    endtask

    task automatic wait_vs_low(output int c);
        int n = 0;
        while (vsync && n < 5000) begin tick(); n++; end
        c = cyc;
    endtask

    task automatic run_frame(input int L, input int G, input int T,
                             input int W, input int nl, input logic [3:0] lanes);
        int k, c, m;
        fs = 1; tick(); k = cyc;
        chk("R2 vsync on start", vsync, 1);
        chk("R9 lane_act", lane_act, lanes);
        m = k;
        for (int i = 0; i < nl; i++) begin
            ls = 1; tick(); wait_hs(c);
            if (i == 0) chk("R4 lead-in", c - k, 1 + L);
            else        chk("R5 line gap", c - m, 1 + G);
            chk("R11 pix_valid", pix_valid, 1);
            repeat (W - 1) tick();
            le = 1; if (i == nl - 1) fe = 1;
            tick(); m = cyc;
            chk("R11 hsync low after end", hsync, 0);
        end
        wait_vs_low(c);
        chk("R6 tail", c - m, 1 + T);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int c, k, m;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        tick();
        // R1 reset state
        chk("R1 vsync", vsync, 0);
        chk("R1 hsync", hsync, 0);
        chk("R1 pix_valid", pix_valid, 0);
        chk("R1 lane_act", lane_act, 0);
        chk("R1 fmt_err", fmt_err, 1);
        chk("R1 pend_ovf", pend_ovf, 0);

        // R8 reserved code refuses frames
        write_en(5'b11111);
        chk("R3 lanes not yet taken", lane_act, 4'b0001);
        fs = 1; tick();
        chk("R8 frame refused code 0", vsync, 0);
        write_cfg(1, 1, 1, 6'h2D, 2'b11);
        chk("R8 fmt_err 0x2D", fmt_err, 1);
        fs = 1; tick();
        chk("R8 frame refused 0x2D", vsync, 0);
        write_cfg(0, 0, 0, 6'h2A, 2'b01);
        chk("R8 fmt_err legal", fmt_err, 0);

        // R2 clock lane off refuses frames
        write_en(5'b11110);
        fs = 1; tick();
        chk("R2 frame refused lane off", vsync, 0);
        write_en(5'b11111);

        // zero gaps
        run_frame(0, 0, 0, 1, 3, 4'b0011);

        // R3 mid-frame config write applies to next frame
        write_cfg(2, 1, 3, 6'h1E, 2'b11);
        fs = 1; tick(); k = cyc;
        ls = 1; tick(); wait_hs(c);
        chk("R4 lead-in 1", c - k, 2);
        write_cfg(9, 0, 0, 6'h2B, 2'b00);
        chk("R3 lanes unchanged mid-frame", lane_act, 4'b1111);
        le = 1; tick(); m = cyc;
        ls = 1; tick(); wait_hs(c);
        chk("R3 old line gap kept", c - m, 3);
        le = 1; fe = 1; tick(); m = cyc;
        wait_vs_low(c);
        chk("R3 old tail kept", c - m, 4);
        run_frame(0, 9, 0, 2, 2, 4'b0001);

        // R12 frame end with no lines; later line starts ignored
        write_cfg(0, 0, 5, 6'h2C, 2'b10);
        fs = 1; tick(); k = cyc;
        le = 1; tick();
        chk("R11 stray line_end ignored", vsync, 1);
        fe = 1; tick();
        ls = 1; tick();
        chk("R12 line start after end ignored", hsync, 0);
        wait_vs_low(c);
        chk("R6 tail from start", c - k, 6);
        chk("R12 no line served", hsync, 0);

        // R10 clock lane cleared mid-line
        fs = 1; tick();
        ls = 1; tick(); wait_hs(c);
        write_en(5'b00000);
        chk("R10 vsync drop", vsync, 0);
        chk("R10 hsync drop", hsync, 0);
        chk("R10 pix_valid drop", pix_valid, 0);
        tick();
        write_en(5'b11111);
        chk("R10 stays idle", vsync, 0);

        // random frames
        for (int f = 0; f < 14; f++) begin
            int L, G, T, W, nl;
            logic [1:0] n;
            logic [4:0] e;
            L = $urandom % 8; G = $urandom % 8; T = $urandom % 20;
            W = 1 + $urandom % 4; nl = 1 + $urandom % 3;
            n = 2'($urandom % 4);
            e = {4'($urandom % 16), 1'b1};
            write_en(e);
            write_cfg(G, L, T, legal_fmt($urandom % 8), n);
            run_frame(L, G, T, W, nl, e[4:1] & exp_mask(n));
        end
        chk("R7 single early start no overflow", pend_ovf, 0);

        // R7 overflow on second early start
        write_en(5'b11111);
        write_cfg(6, 0, 0, 6'h30, 2'b11);
        fs = 1; tick(); k = cyc;
        ls = 1; tick();
        chk("R4 zero lead-in", hsync, 1);
        le = 1; tick(); m = cyc;
        ls = 1; tick();
        chk("R7 one pending ok", pend_ovf, 0);
        ls = 1; tick();
        chk("R7 overflow set", pend_ovf, 1);
        wait_hs(c);
        chk("R7 pending served at gap", c - m, 7);
        le = 1; fe = 1; tick(); m = cyc;
        wait_vs_low(c);
        chk("R6 zero tail", c - m, 1);
        chk("R7 overflow sticky", pend_ovf, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule